// File: doc/BRIEF.md
# Double-Buffered Multichannel DAC Register Controller

This block is the register front end for a bank of 12-bit voltage-output converters. Each channel has two stages. An input stage is loaded by bus writes. An output stage drives the converter code. A word-addressed slave port with a single-cycle select strobe gives access to the channel stages, to two dataless mode-select locations and to a dataless update trigger.

In pass-through mode, a channel write reaches that channel's output stage in the same clock edge. In batched mode, writes collect in the input stages, and one trigger write moves every input stage to its output stage together. The trigger also returns the block to batched mode.

The same port returns per-channel calibration bytes from a small computed table. Every access that the block supports is acknowledged with no wait states. The output stages are presented as one packed vector of 12-bit codes.

Top module: `dacbank_ctrl`

## Requirements
- R1: The `addr` port carries a word index, which is the byte offset divided by 2. Word index c, for c = 0 to NUM_CH-1, is the channel-c data register, so channel c sits at byte offset 2c. Channel c's code appears at `dac_codes[12c+11:12c]`.
- R2: A channel write stores `wdata[15:4]` as the 12-bit code. The value of `wdata[3:0]` has no effect on any code.
- R3: In pass-through mode, a channel write changes that channel's code at the clock edge that ends the access. No other channel's code changes.
- R4: In batched mode, a channel write leaves every output code unchanged.
- R5: A write to word 12h (byte 24h) copies every channel's input stage to its output stage in one clock edge.
- R6: A write to word 10h (byte 20h) selects pass-through mode. A write to word 11h (byte 22h) selects batched mode. The write data is ignored. A trigger write made in pass-through mode also selects batched mode.
- R7: Reset selects batched mode and sets every code to 800h, the zero-volt value in offset binary. Reset leaves the input stages untouched.
- R8: A read of word 20h+2c returns channel c's offset byte on `rd_data[7:0]`, and a read of word 21h+2c returns its gain byte, with `rd_data[15:8]` = 0. The offset byte is (CAL_SEED + 29·c) mod 256 and the gain byte is (F0h − 3·c) mod 256. `rd_data` is 0 whenever no calibration read is acknowledged.
- R9: `ack` is high only while `sel` is high, in the same cycle as the access, so each one-cycle strobe gets exactly one acknowledge cycle.
- R10: Reads of channel, mode or trigger words, reads or writes of unused words, and writes to the calibration words get no acknowledge.
- R11: With NUM_CH = 8, channel words 8 to 15 and the calibration bytes of channels 8 to 15 are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | One-cycle qualified access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 6 | Word index (byte offset / 2) |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid in the acknowledged cycle |
| ack | output | 1 | Access acknowledge, same cycle as `sel` |
| dac_codes | output | NUM_CH*12 | Output-stage codes, channel 0 in the low bits |

## Verification
On every cycle, the bound checker enforces these properties:
- acknowledge only under a strobe;
- silence on reads of the write-only words;
- a clean upper read byte;
- output codes frozen in batched mode unless a trigger is present;
- the mode falling back after a trigger;
- midscale codes on the first cycle after reset.

Only the bench scenarios can show the behaviour that depends on data. That covers which channel a write lands on and the discarded low nibble. It also covers the calibration byte values, and the input stages keeping their contents through reset so that a later trigger restores them. Finally, the scenarios check the narrower eight-channel build's address limits.

// File: rtl/dacb_pkg.sv
package dacb_pkg;
  localparam int WORD_W = 16;
  localparam int CODE_W = 12;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_PASS  = 6'h10;
  localparam logic [ADDR_W-1:0] A_BATCH = 6'h11;
  localparam logic [ADDR_W-1:0] A_TRIG  = 6'h12;

  localparam logic [CODE_W-1:0] MIDSCALE = 12'h800;

  typedef struct packed {
    logic chan_we;
    logic go_pass;
    logic go_batch;
    logic trig;
    logic cal_rd;
  } dacb_strobe_t;

  // Calibration byte for one channel: offset or gain
  function automatic logic [7:0] cal_byte(input logic [3:0] ch,
                                          input logic       is_gain,
                                          input logic [7:0] seed);
    logic [7:0] c8;
    c8 = {4'b0000, ch};
    return is_gain ? (8'hF0 - c8 * 8'd3) : (seed + c8 * 8'd29);
  endfunction

  // 12-bit code is left-justified in the bus word
  function automatic logic [CODE_W-1:0] word_to_code(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: CODE_W];
  endfunction
endpackage

// File: rtl/dacb_decode.sv
module dacb_decode
  import dacb_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CHW = $clog2(NUM_CH)
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output dacb_strobe_t      stb,
  output logic [CHW-1:0]    ch_idx,
  output logic [CHW-1:0]    cal_ch,
  output logic              cal_is_gain,
  output logic              ack
);
  localparam logic [6:0] NCH7 = 7'(NUM_CH);

  logic chan_hit, cal_hit;

  always_comb begin
    chan_hit     = ({1'b0, addr} < NCH7);
    cal_hit      = addr[5] && ({3'b000, addr[4:1]} < NCH7);
    stb.chan_we  = sel && wr && chan_hit;
    stb.go_pass  = sel && wr && (addr == A_PASS);
    stb.go_batch = sel && wr && (addr == A_BATCH);
    stb.trig     = sel && wr && (addr == A_TRIG);
    stb.cal_rd   = sel && !wr && cal_hit;
    ack          = |stb;
  end

  assign ch_idx      = addr[CHW-1:0];
  assign cal_ch      = addr[CHW:1];
  assign cal_is_gain = addr[0];
endmodule

// File: rtl/dacb_lanes.sv
module dacb_lanes
  import dacb_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CHW = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     chan_we,
  input  logic [CHW-1:0]           ch_idx,
  input  logic [CODE_W-1:0]        wcode,
  input  logic                     pass_mode,
  input  logic                     trig,
  output logic [NUM_CH*CODE_W-1:0] codes
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    logic              lane_we;
    logic [CODE_W-1:0] in_q;
    logic [CODE_W-1:0] out_q;

    assign lane_we = chan_we && (ch_idx == CHW'(g));

    // Input stage: deliberately without reset
    always_ff @(posedge clk) begin
      if (lane_we) in_q <= wcode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    out_q <= MIDSCALE;
      else if (trig)                 out_q <= in_q;
      else if (lane_we && pass_mode) out_q <= wcode;
    end

    assign codes[g*CODE_W +: CODE_W] = out_q;
  end
endmodule

// File: rtl/dacb_calrom.sv
module dacb_calrom
  import dacb_pkg::*;
#(
  parameter int         NUM_CH   = 16,
  parameter logic [7:0] CAL_SEED = 8'h5A,
  localparam int CHW = $clog2(NUM_CH)
) (
  input  logic              cal_rd,
  input  logic [CHW-1:0]    cal_ch,
  input  logic              is_gain,
  output logic [WORD_W-1:0] rd_data
);
  logic [7:0] offs [NUM_CH];
  logic [7:0] gain [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cal
    assign offs[g] = cal_byte(4'(g), 1'b0, CAL_SEED);
    assign gain[g] = cal_byte(4'(g), 1'b1, CAL_SEED);
  end

  always_comb begin
    rd_data = '0;
    if (cal_rd) rd_data[7:0] = is_gain ? gain[cal_ch] : offs[cal_ch];
  end
endmodule

// File: rtl/dacbank_ctrl.sv
module dacbank_ctrl
  import dacb_pkg::*;
#(
  parameter int         NUM_CH   = 16,
  parameter logic [7:0] CAL_SEED = 8'h5A
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel,
  input  logic                     wr,
  input  logic [5:0]               addr,
  input  logic [15:0]              wdata,
  output logic [15:0]              rd_data,
  output logic                     ack,
  output logic [NUM_CH*12-1:0]     dac_codes
);
  localparam int CHW = $clog2(NUM_CH);

  dacb_strobe_t   stb;
  logic [CHW-1:0] ch_idx, cal_ch;
  logic           cal_is_gain;
  logic           chan_we, trig_pulse, xparent_q;
  logic           wdata_unused;

  assign wdata_unused = ^wdata[3:0];
  assign chan_we      = stb.chan_we;
  assign trig_pulse   = stb.trig;

  dacb_decode #(.NUM_CH(NUM_CH)) u_dec (
    .sel(sel), .wr(wr), .addr(addr), .stb(stb),
    .ch_idx(ch_idx), .cal_ch(cal_ch), .cal_is_gain(cal_is_gain), .ack(ack)
  );

  // Mode register: 1 = pass-through, 0 = batched
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        xparent_q <= 1'b0;
    else if (stb.go_pass)              xparent_q <= 1'b1;
    else if (stb.go_batch || stb.trig) xparent_q <= 1'b0;
  end

  dacb_lanes #(.NUM_CH(NUM_CH)) u_lanes (
    .clk(clk), .rst_n(rst_n), .chan_we(chan_we), .ch_idx(ch_idx),
    .wcode(word_to_code(wdata)), .pass_mode(xparent_q), .trig(trig_pulse),
    .codes(dac_codes)
  );

  dacb_calrom #(.NUM_CH(NUM_CH), .CAL_SEED(CAL_SEED)) u_cal (
    .cal_rd(stb.cal_rd), .cal_ch(cal_ch), .is_gain(cal_is_gain), .rd_data(rd_data)
  );
endmodule

// File: rtl/dacb_checker.sv
module dacb_checker #(
  parameter int NUM_CH = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sel,
  input logic                 wr,
  input logic [5:0]           addr,
  input logic [15:0]          rd_data,
  input logic                 ack,
  input logic [NUM_CH*12-1:0] dac_codes,
  input logic                 trig_pulse,
  input logic                 xparent_q
);
  localparam logic [NUM_CH*12-1:0] ALL_MID = {NUM_CH{12'h800}};

  a_r9_ack_only_with_sel: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> sel);

  a_r10_no_ack_read_low_words: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && !addr[5]) |-> !ack);

  a_r8_upper_byte_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr) |-> (rd_data[15:8] == 8'h00));

  a_r8_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (rd_data == 16'h0000));

  a_r4_batched_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!xparent_q && !trig_pulse) |=> $stable(dac_codes));

  a_r6_trig_leaves_pass: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !xparent_q);

  a_r7_reset_midscale: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (dac_codes == ALL_MID));
endmodule

bind dacbank_ctrl dacb_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
  .rd_data(rd_data), .ack(ack), .dac_codes(dac_codes),
  .trig_pulse(trig_pulse), .xparent_q(xparent_q)
);

// File: tb/test_dacbank_ctrl.sv
module test_dacbank_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel = 1'b0, wr = 1'b0;
  logic [5:0]   addr = '0;
  logic [15:0]  wdata = '0;
  logic [15:0]  rd_data, rd8;
  logic         ack, ack8;
  logic [191:0] dac_codes;
  logic [95:0]  codes8;
  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic last_k8;

  always #2 clk = ~clk;

  dacbank_ctrl i_dacbank_ctrl (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .ack(ack), .dac_codes(dac_codes));

  dacbank_ctrl #(.NUM_CH(8)) i_dacbank_ctrl_n8 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .rd_data(rd8), .ack(ack8), .dac_codes(codes8));

  typedef struct packed {
    logic        w;
    logic [5:0]  a;
    logic [15:0] d;
    logic        k;
    logic [15:0] q;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'h20, 16'h0000, 1'b1, 16'h005A},  // R8 ch0 offset
    '{1'b0, 6'h21, 16'h0000, 1'b1, 16'h00F0},  // R8 ch0 gain
    '{1'b0, 6'h2E, 16'h0000, 1'b1, 16'h0025},  // R8 ch7 offset
    '{1'b0, 6'h3F, 16'h0000, 1'b1, 16'h00C3},  // R8 ch15 gain
    '{1'b0, 6'h3E, 16'h0000, 1'b1, 16'h000D},  // R8 ch15 offset
    '{1'b0, 6'h00, 16'h0000, 1'b0, 16'h0000},  // R10 read channel word
    '{1'b0, 6'h10, 16'h0000, 1'b0, 16'h0000},  // R10 read mode word
    '{1'b0, 6'h12, 16'h0000, 1'b0, 16'h0000},  // R10 read trigger word
    '{1'b0, 6'h13, 16'h0000, 1'b0, 16'h0000},  // R10 unused read
    '{1'b1, 6'h13, 16'h5555, 1'b0, 16'h0000},  // R10 unused write
    '{1'b1, 6'h20, 16'hAAAA, 1'b0, 16'h0000},  // R10 write to cal word
    '{1'b1, 6'h11, 16'h1234, 1'b1, 16'h0000},  // R6 batched select
    '{1'b0, 6'h1F, 16'h0000, 1'b0, 16'h0000},  // R10 unused gap read
    '{1'b1, 6'h0D, 16'hABCD, 1'b1, 16'h0000}   // R1 channel 13 write
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [5:0] a, input logic [15:0] d,
                     output logic k, output logic [15:0] q);
    @(negedge clk);
    sel = 1'b1; wr = w; addr = a; wdata = d;
    #1;
    k = ack; q = rd_data; last_k8 = ack8;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    #1;
  endtask

  function automatic logic [11:0] code_of(input int i);
    return dac_codes[i*12 +: 12];
  endfunction

  function automatic logic [15:0] pattern(input int i);
    return {4'(i), 4'(15 - i), 4'(i + 3), 4'hF};
  endfunction

  initial begin
    logic k;
    logic [15:0] q;
    logic [7:0] exp_off;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int i = 0; i < 16; i++) chk("R7 reset code", code_of(i), 12'h800);

    for (int v = 0; v < NV; v++) begin
      acc(VECS[v].w, VECS[v].a, VECS[v].d, k, q);
      chk($sformatf("R8/R10 vector %0d ack", v), k, VECS[v].k);
      chk($sformatf("R8/R10 vector %0d data", v), q, VECS[v].q);
    end

    // R8 full sweep of offset bytes, recomputed by accumulation
    exp_off = 8'h5A;
    for (int c = 0; c < 16; c++) begin
      acc(1'b0, 6'(32 + 2 * c), 16'h0, k, q);
      chk("R8 offset sweep", q, {8'h00, exp_off});
      exp_off = exp_off + 8'd29;
    end

    // R4: batched writes leave codes alone
    for (int i = 0; i < 16; i++) acc(1'b1, 6'(i), pattern(i), k, q);
    for (int i = 0; i < 16; i++) chk("R4 held in batched mode", code_of(i), 12'h800);

    // R5 / R1 / R2: trigger moves everything at once
    acc(1'b1, 6'h12, 16'h0000, k, q);
    chk("R5 trigger ack", k, 1'b1);
    for (int i = 0; i < 16; i++) chk("R5 R1 R2 triggered code", code_of(i), pattern(i) >> 4);

    // R3: pass-through write
    acc(1'b1, 6'h10, 16'h0000, k, q);
    acc(1'b1, 6'h05, 16'h3C5A, k, q);
    chk("R3 pass-through update", code_of(5), 12'h3C5);
    chk("R3 neighbour untouched", code_of(6), pattern(6) >> 4);

    // R6: trigger from pass-through returns to batched mode
    acc(1'b1, 6'h12, 16'hFFFF, k, q);
    acc(1'b1, 6'h05, 16'h7771, k, q);
    chk("R6 batched after trigger", code_of(5), 12'h3C5);
    acc(1'b1, 6'h12, 16'h0000, k, q);
    chk("R5 second trigger", code_of(5), 12'h777);

    // R7: reset mid-run, input stages survive
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    for (int i = 0; i < 16; i++) chk("R7 reset clears codes", code_of(i), 12'h800);
    rst_n = 1'b1;
    acc(1'b1, 6'h00, 16'h1230, k, q);
    chk("R7 batched after reset", code_of(0), 12'h800);
    acc(1'b1, 6'h12, 16'h0000, k, q);
    chk("R7 ch0 after trigger", code_of(0), 12'h123);
    chk("R7 input stage kept", code_of(1), pattern(1) >> 4);
    chk("R7 input stage kept ch5", code_of(5), 12'h777);

    // R9: no strobe, no acknowledge
    @(negedge clk);
    addr = 6'h00; wr = 1'b1;
    #1;
    chk("R9 idle ack", ack, 1'b0);
    wr = 1'b0;

    // R11: eight-channel build
    acc(1'b1, 6'h07, 16'h0000, k, q);
    chk("R11 ch7 ack", last_k8, 1'b1);
    acc(1'b1, 6'h08, 16'h0000, k, q);
    chk("R11 ch8 no ack", last_k8, 1'b0);
    chk("R11 full build ch8 ack", k, 1'b1);
    acc(1'b0, 6'h2F, 16'h0000, k, q);
    chk("R11 ch7 gain ack", last_k8, 1'b1);
    acc(1'b0, 6'h30, 16'h0000, k, q);
    chk("R11 ch8 cal no ack", last_k8, 1'b0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule